// File: doc/BRIEF.md
# Host-Firmware Mailbox with Ownership Arbitration

This block is a register-mapped mailbox between a host processor and an embedded controller CPU. The host reaches it over a 32-bit register bus with single-cycle read and write strobes. Five words are visible to the host: a command word, an inbound data word that the host fills for the firmware, an outbound data word that the firmware fills for the host, an owner word and an interrupt status word. The owner word arbitrates use of the mailbox. The host may claim it only while it is free. The firmware frees it to show that a host command has completed.

The firmware side is a plain signal port. A post strobe loads the outbound word, marks the mailbox as firmware-owned and raises a level interrupt toward the host. A done strobe returns ownership to free. A hang strobe sets a sticky flag in the status word. The firmware gets a one-cycle interrupt pulse whenever the host writes the command word with the controller-CPU destination and interrupt enable both set. The firmware also sees the inbound word, split into its type and payload fields, with flags that decode the two response codes.

Top module: `hfw_mailbox`

## Requirements
- R1: After synchronous reset the owner word, command word and status word read 0, and `host_irq` and `fw_irq` are low.
- R2: A data word carries its message type in bits [31:24] and its payload in bits [23:0]. The inbound word at word address 1 is presented on `fw_in_type`/`fw_in_payload`. A post makes the outbound word at word address 2 read {`fw_post_type`, `fw_post_payload`}.
- R3: The owner word at word address 3 encodes 0 as free, 1 as firmware-owned and 2 as host-owned. A host write of value 2 claims the mailbox (reads back 2) only if the owner was 0.
- R4: A host write of value 0 to the owner word releases the mailbox only while it is host-owned. Any other host write to the owner word is ignored.
- R5: A `fw_done` strobe returns the owner word to 0 on the next edge, whoever owned it. It has priority over posts and host writes in the same cycle.
- R6: A `fw_post` while the owner is 0 loads the outbound word, sets the owner to 1 and sets the SMI destination bit (bit 29 of the command word). A post while the owner is not 0 is ignored.
- R7: `host_irq` is a registered level, high one cycle after the SMI destination bit is set or after the status hang flag and the status enable bit are both set.
- R8: A host write with bit 29 at 0 clears the SMI destination bit, which acknowledges a firmware message. A host write with bit 29 at 1 cannot set it.
- R9: A host write to the command word (word address 0) with both bit 31 (interrupt enable) and bit 27 (controller-CPU destination) set produces a one-cycle pulse on `fw_irq` after that edge. No pulse follows if either bit is 0.
- R10: The status word at word address 4 holds a writable enable at bit 3 and a hang flag at bit 1. `fw_hang` sets the hang flag. Writing back the value read clears the hang flag and keeps the enable.
- R11: `fw_in_ack` is high when the inbound type field is 0x80, and `fw_in_nak` is high when it is 0x81.
- R12: The command word keeps only bits [31:27] (31 enable, 30 host-controller, 29 SMI, 28 PME, 27 controller CPU) and reads 0 elsewhere. The outbound word cannot be written by the host. Unmapped addresses read 0. Read data appears on `host_rdata` one edge after `host_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| host_irq | output | 1 | Level interrupt toward the host |
| fw_post | input | 1 | Firmware posts a message to the host |
| fw_post_type | input | 8 | Type of the posted message |
| fw_post_payload | input | 24 | Payload of the posted message |
| fw_done | input | 1 | Firmware frees the mailbox |
| fw_hang | input | 1 | Firmware hang event |
| fw_irq | output | 1 | One-cycle interrupt pulse toward the firmware |
| fw_in_type | output | 8 | Type field of the inbound word |
| fw_in_payload | output | 24 | Payload field of the inbound word |
| fw_in_ack | output | 1 | Inbound type is the ACK code |
| fw_in_nak | output | 1 | Inbound type is the NAK code |
| fw_owner | output | 2 | Current owner encoding |

## Verification
The bound checker watches the ownership rules on every cycle. A move to host-owned must follow a claim write made while the mailbox was free. Firmware ownership never passes straight to the host. A done strobe always frees the mailbox, and an accepted post always yields firmware ownership with the SMI bit set. The checker also confirms that the firmware interrupt lasts one cycle and that a set SMI bit is followed by the host interrupt. Some behaviours only the bench scenarios can show: ignored writes leaving register contents unchanged, field packing of the data words, clear-by-writeback of the status flag, the enable gating of the hang interrupt, and the ACK/NAK decodes.

// File: rtl/mb_pkg.sv
package mb_pkg;
  localparam int MB_PAYLOAD_W = 24;
  localparam int MB_TYPE_W    = 8;

  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_FW   = 2'd1,
    OWN_HOST = 2'd2
  } owner_e;

  // command field: top five bits of the word, indexed from its LSB
  localparam int CMD_FIELD_W = 5;
  localparam int F_CPU       = 0;
  localparam int F_PME       = 1;
  localparam int F_SMI       = 2;
  localparam int F_HOSTCTL   = 3;
  localparam int F_IE        = 4;

  // status word bit positions
  localparam int ST_HANG = 1;
  localparam int ST_EN   = 3;

  // response type codes
  localparam logic [7:0] RESP_ACK = 8'h80;
  localparam logic [7:0] RESP_NAK = 8'h81;

  // word addresses
  localparam int A_CMD   = 0;
  localparam int A_DIN   = 1;
  localparam int A_DOUT  = 2;
  localparam int A_OWNER = 3;
  localparam int A_STAT  = 4;
endpackage

// File: rtl/mb_owner_arb.sv
module mb_owner_arb
  import mb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   host_wr_owner,
  input  logic   wr_claim,
  input  logic   wr_release,
  input  logic   fw_post,
  input  logic   fw_done,
  output owner_e owner,
  output logic   post_accept
);
  owner_e owner_d;

  always_comb begin
    post_accept = fw_post && !fw_done && (owner == OWN_FREE);
    owner_d     = owner;
    if (fw_done) begin
      owner_d = OWN_FREE;
    end else if (post_accept) begin
      owner_d = OWN_FW;
    end else if (host_wr_owner) begin
      if (owner == OWN_FREE && wr_claim) begin
        owner_d = OWN_HOST;
      end else if (owner == OWN_HOST && wr_release) begin
        owner_d = OWN_FREE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owner <= OWN_FREE;
    else     owner <= owner_d;
  end
endmodule

// File: rtl/mb_cmd_reg.sv
module mb_cmd_reg
  import mb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_cmd,
  input  logic [CMD_FIELD_W-1:0] wfield,
  input  logic                   post_accept,
  output logic [CMD_FIELD_W-1:0] field,
  output logic                   fw_irq
);
  logic [CMD_FIELD_W-1:0] field_d;

  always_comb begin
    field_d = field;
    if (wr_cmd) begin
      field_d        = wfield;
      // host may only clear the message-pending bit
      field_d[F_SMI] = wfield[F_SMI] & field[F_SMI];
    end
    if (post_accept) field_d[F_SMI] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field  <= '0;
      fw_irq <= 1'b0;
    end else begin
      field  <= field_d;
      fw_irq <= wr_cmd & wfield[F_IE] & wfield[F_CPU];
    end
  end
endmodule

// File: rtl/mb_irq_stat.sv
module mb_irq_stat (
  input  logic clk,
  input  logic rst,
  input  logic wr_stat,
  input  logic w_en,
  input  logic w_hang,
  input  logic fw_hang,
  input  logic smi,
  output logic en,
  output logic hang,
  output logic host_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      hang     <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      if (wr_stat) en <= w_en;
      if (fw_hang)                hang <= 1'b1;
      else if (wr_stat && w_hang) hang <= 1'b0;
      host_irq <= smi | (hang & en);
    end
  end
endmodule

// File: rtl/hfw_mailbox.sv
module hfw_mailbox
  import mb_pkg::*;
#(
  parameter int PAYLOAD_W = MB_PAYLOAD_W,
  parameter int TYPE_W    = MB_TYPE_W,
  parameter int ADDR_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          host_wr,
  input  logic                          host_rd,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [PAYLOAD_W+TYPE_W-1:0]   host_wdata,
  output logic [PAYLOAD_W+TYPE_W-1:0]   host_rdata,
  output logic                          host_irq,
  input  logic                          fw_post,
  input  logic [TYPE_W-1:0]             fw_post_type,
  input  logic [PAYLOAD_W-1:0]          fw_post_payload,
  input  logic                          fw_done,
  input  logic                          fw_hang,
  output logic                          fw_irq,
  output logic [TYPE_W-1:0]             fw_in_type,
  output logic [PAYLOAD_W-1:0]          fw_in_payload,
  output logic                          fw_in_ack,
  output logic                          fw_in_nak,
  output logic [1:0]                    fw_owner
);
  localparam int WORD_W  = PAYLOAD_W + TYPE_W;
  localparam int CMD_LSB = WORD_W - CMD_FIELD_W;

  logic wr_cmd, wr_din, wr_owner, wr_stat;
  logic [WORD_W-1:0] din_q, dout_q, rd_mux;
  logic [CMD_FIELD_W-1:0] cmd_field;
  logic post_accept, smi_bit, st_en, st_hang;
  owner_e owner;

  always_comb begin
    wr_cmd   = host_wr && (host_addr == ADDR_W'(A_CMD));
    wr_din   = host_wr && (host_addr == ADDR_W'(A_DIN));
    wr_owner = host_wr && (host_addr == ADDR_W'(A_OWNER));
    wr_stat  = host_wr && (host_addr == ADDR_W'(A_STAT));
  end

  mb_owner_arb u_arb (
    .clk           (clk),
    .rst           (rst),
    .host_wr_owner (wr_owner),
    .wr_claim      (host_wdata == WORD_W'(OWN_HOST)),
    .wr_release    (host_wdata == '0),
    .fw_post       (fw_post),
    .fw_done       (fw_done),
    .owner         (owner),
    .post_accept   (post_accept)
  );

  mb_cmd_reg u_cmd (
    .clk         (clk),
    .rst         (rst),
    .wr_cmd      (wr_cmd),
    .wfield      (host_wdata[WORD_W-1:CMD_LSB]),
    .post_accept (post_accept),
    .field       (cmd_field),
    .fw_irq      (fw_irq)
  );

  assign smi_bit = cmd_field[F_SMI];

  mb_irq_stat u_stat (
    .clk      (clk),
    .rst      (rst),
    .wr_stat  (wr_stat),
    .w_en     (host_wdata[ST_EN]),
    .w_hang   (host_wdata[ST_HANG]),
    .fw_hang  (fw_hang),
    .smi      (smi_bit),
    .en       (st_en),
    .hang     (st_hang),
    .host_irq (host_irq)
  );

  // data words and response decode
  always_ff @(posedge clk) begin
    if (rst) begin
      din_q     <= '0;
      dout_q    <= '0;
      fw_in_ack <= 1'b0;
      fw_in_nak <= 1'b0;
    end else begin
      if (wr_din) begin
        din_q     <= host_wdata;
        fw_in_ack <= host_wdata[WORD_W-1:PAYLOAD_W] == TYPE_W'(RESP_ACK);
        fw_in_nak <= host_wdata[WORD_W-1:PAYLOAD_W] == TYPE_W'(RESP_NAK);
      end
      if (post_accept) dout_q <= {fw_post_type, fw_post_payload};
    end
  end

  assign fw_in_type    = din_q[WORD_W-1:PAYLOAD_W];
  assign fw_in_payload = din_q[PAYLOAD_W-1:0];
  assign fw_owner      = owner;

  always_comb begin
    rd_mux = '0;
    case (host_addr)
      ADDR_W'(A_CMD):   rd_mux = {cmd_field, {CMD_LSB{1'b0}}};
      ADDR_W'(A_DIN):   rd_mux = din_q;
      ADDR_W'(A_DOUT):  rd_mux = dout_q;
      ADDR_W'(A_OWNER): rd_mux = WORD_W'(owner);
      ADDR_W'(A_STAT): begin
        rd_mux[ST_EN]   = st_en;
        rd_mux[ST_HANG] = st_hang;
      end
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end
endmodule

// File: rtl/mb_checker.sv
module mb_checker #(
  parameter int ADDR_W = 3,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [WORD_W-1:0] host_wdata,
  input logic              fw_post,
  input logic              fw_done,
  input logic              fw_irq,
  input logic              host_irq,
  input logic [1:0]        owner,
  input logic              smi
);
  // R3: host ownership only follows a claim made while free
  a_r3_claim_from_free: assert property (@(posedge clk) disable iff (rst)
    (owner == 2'd2 && $past(owner) != 2'd2) |->
      ($past(owner) == 2'd0 && $past(host_wr) &&
       $past(host_addr) == ADDR_W'(3) && $past(host_wdata) == WORD_W'(2)));

  // R4: firmware ownership never hands straight over to the host
  a_r4_no_fw_to_host: assert property (@(posedge clk) disable iff (rst)
    (owner == 2'd1) |=> (owner != 2'd2));

  // R5: done always frees the mailbox
  a_r5_done_frees: assert property (@(posedge clk) disable iff (rst)
    fw_done |=> (owner == 2'd0));

  // R6: accepted post gives firmware ownership and a pending host message
  a_r6_post_takes: assert property (@(posedge clk) disable iff (rst)
    (fw_post && !fw_done && owner == 2'd0) |=> (owner == 2'd1 && smi));

  // R7: pending message raises the host interrupt one cycle later
  a_r7_smi_irq: assert property (@(posedge clk) disable iff (rst)
    smi |=> host_irq);

  // R9: firmware interrupt is a single-cycle pulse
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fw_irq |=> !fw_irq);
endmodule

bind hfw_mailbox mb_checker #(
  .ADDR_W (ADDR_W),
  .WORD_W (PAYLOAD_W + TYPE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .fw_post    (fw_post),
  .fw_done    (fw_done),
  .fw_irq     (fw_irq),
  .host_irq   (host_irq),
  .owner      (fw_owner),
  .smi        (smi_bit)
);

// File: tb/hfw_mailbox_tb.sv
`timescale 1ns/1ps
module hfw_mailbox_tb;
  localparam logic       OP_R = 1'b0;
  localparam logic       OP_W = 1'b1;
  localparam logic [2:0] AD_CMD = 3'd0, AD_DIN = 3'd1, AD_DOUT = 3'd2,
                         AD_OWN = 3'd3, AD_STAT = 3'd4, AD_NONE = 3'd6;
  localparam int NV = 18;
  // {op, addr, data, expected, requirement number}
  localparam logic [71:0] VEC [NV] = '{
    {OP_R, AD_OWN,  32'h0,        32'h0,        4'd1},  // R1
    {OP_R, AD_CMD,  32'h0,        32'h0,        4'd1},  // R1
    {OP_R, AD_STAT, 32'h0,        32'h0,        4'd1},  // R1
    {OP_W, AD_OWN,  32'h2,        32'h0,        4'd3},
    {OP_R, AD_OWN,  32'h0,        32'h2,        4'd3},  // R3 claim
    {OP_W, AD_OWN,  32'h1,        32'h0,        4'd4},
    {OP_R, AD_OWN,  32'h0,        32'h2,        4'd4},  // R4 ignored
    {OP_W, AD_DIN,  32'h81ABCDEF, 32'h0,        4'd2},
    {OP_R, AD_DIN,  32'h0,        32'h81ABCDEF, 4'd2},  // R2
    {OP_W, AD_DOUT, 32'hFFFFFFFF, 32'h0,        4'd12},
    {OP_R, AD_DOUT, 32'h0,        32'h0,        4'd12}, // R12 read-only
    {OP_W, AD_CMD,  32'hFFFFFFFF, 32'h0,        4'd12},
    {OP_R, AD_CMD,  32'h0,        32'hD8000000, 4'd12}, // R12, R8
    {OP_R, AD_NONE, 32'h0,        32'h0,        4'd12}, // R12 unmapped
    {OP_W, AD_OWN,  32'h0,        32'h0,        4'd4},
    {OP_R, AD_OWN,  32'h0,        32'h0,        4'd4},  // R4 release
    {OP_W, AD_STAT, 32'h8,        32'h0,        4'd10},
    {OP_R, AD_STAT, 32'h0,        32'h8,        4'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq, fw_irq, fw_in_ack, fw_in_nak;
  logic        fw_post = 1'b0, fw_done = 1'b0, fw_hang = 1'b0;
  logic [7:0]  fw_post_type = '0, fw_in_type;
  logic [23:0] fw_post_payload = '0, fw_in_payload;
  logic [1:0]  fw_owner;

  int checks = 0, errors = 0, cycles = 0;
  logic pulse_seen;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  hfw_mailbox u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .fw_post(fw_post), .fw_post_type(fw_post_type),
    .fw_post_payload(fw_post_payload), .fw_done(fw_done), .fw_hang(fw_hang),
    .fw_irq(fw_irq), .fw_in_type(fw_in_type), .fw_in_payload(fw_in_payload),
    .fw_in_ack(fw_in_ack), .fw_in_nak(fw_in_nak), .fw_owner(fw_owner)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    pulse_seen = fw_irq;
  endtask

  task automatic hread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic pulse_fw(input int which);
    @(negedge clk);
    if (which == 0) fw_post = 1'b1;
    else if (which == 1) fw_done = 1'b1;
    else fw_hang = 1'b1;
    @(negedge clk);
    fw_post = 1'b0; fw_done = 1'b0; fw_hang = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset outputs
    check("R1 fw_owner", {30'b0, fw_owner}, 32'h0);
    check("R1 irqs", {30'b0, host_irq, fw_irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71] == OP_W) hwrite(VEC[i][70:68], VEC[i][67:36]);
      else begin
        hread(VEC[i][70:68], rd);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
      end
    end

    // R11 / R2: inbound decode
    check("R11 nak", {30'b0, fw_in_ack, fw_in_nak}, 32'h1);
    hwrite(AD_DIN, 32'h80000005);
    check("R11 ack", {30'b0, fw_in_ack, fw_in_nak}, 32'h2);
    check("R2 in fields", {fw_in_type, fw_in_payload}, 32'h80000005);

    // R9: firmware interrupt pulse only with both bits
    hwrite(AD_CMD, 32'h08000000);
    check("R9 cpu only", {31'b0, pulse_seen}, 32'h0);
    hwrite(AD_CMD, 32'h80000000);
    check("R9 enable only", {31'b0, pulse_seen}, 32'h0);
    hwrite(AD_CMD, 32'h88000000);
    check("R9 pulse", {31'b0, pulse_seen}, 32'h1);
    @(negedge clk);
    check("R9 pulse width", {31'b0, fw_irq}, 32'h0);

    // R6 / R2 / R7: firmware post
    fw_post_type = 8'h12; fw_post_payload = 24'h345678;
    pulse_fw(0);
    check("R6 owner fw", {30'b0, fw_owner}, 32'h1);
    hread(AD_DOUT, rd);
    check("R2 R6 dout", rd, 32'h12345678);
    check("R7 host_irq on post", {31'b0, host_irq}, 32'h1);
    hread(AD_CMD, rd);
    check("R6 smi set", rd, 32'hA8000000);

    // R3 / R4: host locked out while firmware owns
    hwrite(AD_OWN, 32'h2);
    hread(AD_OWN, rd);
    check("R3 claim fails", rd, 32'h1);
    hwrite(AD_OWN, 32'h0);
    hread(AD_OWN, rd);
    check("R4 release ignored", rd, 32'h1);

    // R6: second post ignored
    fw_post_type = 8'h55; fw_post_payload = 24'h000001;
    pulse_fw(0);
    hread(AD_DOUT, rd);
    check("R6 post ignored", rd, 32'h12345678);

    // R8 / R7: host acknowledges by clearing SMI
    hwrite(AD_CMD, 32'h88000000);
    hread(AD_CMD, rd);
    check("R8 smi cleared", rd, 32'h88000000);
    check("R7 host_irq low", {31'b0, host_irq}, 32'h0);

    // R5: done frees, from firmware and from host ownership
    pulse_fw(1);
    check("R5 free from fw", {30'b0, fw_owner}, 32'h0);
    hwrite(AD_OWN, 32'h2);
    check("R3 claim", {30'b0, fw_owner}, 32'h2);
    pulse_fw(1);
    check("R5 free from host", {30'b0, fw_owner}, 32'h0);

    // R10 / R7: hang flag
    pulse_fw(2);
    hread(AD_STAT, rd);
    check("R10 hang set", rd, 32'hA);
    check("R7 hang irq", {31'b0, host_irq}, 32'h1);
    hwrite(AD_STAT, rd);
    hread(AD_STAT, rd);
    check("R10 writeback clears", rd, 32'h8);
    check("R7 irq cleared", {31'b0, host_irq}, 32'h0);
    hwrite(AD_STAT, 32'h0);
    pulse_fw(2);
    hread(AD_STAT, rd);
    check("R10 hang no enable", rd, 32'h2);
    check("R7 masked", {31'b0, host_irq}, 32'h0);

    // R1: reset in mid-run
    pulse_fw(0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 owner after reset", {30'b0, fw_owner}, 32'h0);
    hread(AD_CMD, rd);
    check("R1 cmd after reset", rd, 32'h0);
    check("R1 irq after reset", {31'b0, host_irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule